// File: doc/BRIEF.md
# Width-Adapting DMA Staging Buffer

This block sits between the read phase and the write phase of a single DMA channel. Every transaction first reads from the source side into one 32-bit holding register and then writes that register out to the destination side. When one side is a peripheral that is accessed in bytes or half-words and the other side is word-wide memory, the block splits the word into narrow writes toward the peripheral, or builds a word from narrow peripheral reads before the memory write.

A 4-bit lane pointer names the byte address inside the holding word that the pending narrow access is handling. Lanes are used in little-endian order, and the pointer advances by the access size after each narrow access. The read and write phase logic talk to the block through request/acknowledge pairs. A transfer happens on a clock edge where both the request and the acknowledge are high. Address generation and the bus protocols are handled outside this block.

Top module: `dma_lane_buffer`

## Requirements
- R1: After reset, with the channel enabled, the block requests a read (`rd_req`=1), does not request a write, and `lane_ptr` is 0.
- R2: In memory-to-memory mode (`mode_sel`=00, and also the unused code 11), each transaction is one word read followed by one write of that exact word. `width_sel` has no effect and `xfer_size` stays 00.
- R3: `xfer_size` gives the size of the pending access: 00 word, 01 byte, 10 half-word. It shows the narrow size only when the pending access is on the peripheral side. The reserved width code 11 acts as a word.
- R4: In memory-to-peripheral mode (`mode_sel`=10) with byte width, one word read is followed by four writes. Each write carries byte lane 0, 1, 2 and then 3 on `wr_data[7:0]`, with zeros above, while `lane_ptr` reads 0, 1, 2, 3.
- R5: In memory-to-peripheral mode with half-word width, one word read is followed by two writes. Each write carries bytes 1:0 and then bytes 3:2 on `wr_data[15:0]`, with zeros above, while `lane_ptr` reads 0 and then 2.
- R6: In memory-to-peripheral mode, no new read is requested until the last lane has been written.
- R7: In peripheral-to-memory mode (`mode_sel`=01) with byte width, four reads each take `rd_data[7:0]` into the lane named by `lane_ptr` (0, 1, 2, 3) and ignore the upper read bits. The assembled word is then written once.
- R8: In peripheral-to-memory mode with half-word width, two reads take `rd_data[15:0]` into lanes 0 and 2. A merge leaves the other lanes untouched, and the word write happens only after both halves are filled.
- R9: With word width in either peripheral mode, each transaction is exactly one read and one write of the full word.
- R10: Driving `chan_en` low drops all buffered data and lane progress, and both requests go low. On re-enable, the block starts again with a read at `lane_ptr` 0, and the dropped data is never written.
- R11: A one-cycle `soft_rst` clears the lane pointer and the buffer state, so the next access is a read at `lane_ptr` 0.
- R12: While a request is pending and its acknowledge is low, the request, `lane_ptr` and `wr_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Clears the pointer and buffer state, keeps the inputs' configuration |
| chan_en | input | 1 | Channel enable; low discards buffered data |
| mode_sel | input | 2 | 00 mem-to-mem, 01 periph-to-mem, 10 mem-to-periph |
| width_sel | input | 2 | Peripheral access size: 00 word, 01 byte, 10 half, 11 reserved |
| rd_req | output | 1 | Read phase request |
| rd_ack | input | 1 | Read phase acknowledge; `rd_data` valid |
| rd_data | input | 32 | Read data; narrow reads on the low bits |
| wr_req | output | 1 | Write phase request |
| wr_ack | input | 1 | Write phase acknowledge |
| wr_data | output | 32 | Write data; narrow writes on the low bits |
| xfer_size | output | 2 | Size of the pending access |
| lane_ptr | output | 4 | Byte address inside the holding word for the pending access |

## Verification
The bench goes after lane order and lane position. A design that shifted the wrong way or forgot to clear the upper bits would give narrow writes with bytes swapped or with stale bits above the lane. Half-word filling is checked with distinct halves, so a merge that zeroed the other lanes shows up as a lost half. Disabling in the middle of a drain and a soft reset in the middle of a fill are both followed by a fresh transaction, so a design that kept leftover lanes or an advanced pointer would either write the discarded data or assemble a shifted word. A memory-to-memory run with a byte width, and a peripheral run with the reserved width code, catch a width field that leaks into modes or codes where it must act as a word.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int PTR_W  = 4;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        MODE_MEM2MEM = 2'b00,
        MODE_PER2MEM = 2'b01,
        MODE_MEM2PER = 2'b10,
        MODE_UNUSED  = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic              narrow_rd;
        logic              narrow_wr;
        acc_size_e         size;
        logic [STEP_W-1:0] step;
    } path_cfg_t;

    function automatic logic [STEP_W-1:0] step_of(acc_size_e sz);
        case (sz)
            SZ_BYTE: step_of = 3'd1;
            SZ_HALF: step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

    function automatic path_cfg_t decode_path(logic [1:0] mode, logic [1:0] width);
        path_cfg_t c;
        acc_size_e sz;
        logic      periph;
        sz          = (width == SZ_RSVD) ? SZ_WORD : acc_size_e'(width);
        periph      = (mode == MODE_PER2MEM) || (mode == MODE_MEM2PER);
        c.size      = periph ? sz : SZ_WORD;
        c.narrow_rd = (mode == MODE_PER2MEM) && (c.size != SZ_WORD);
        c.narrow_wr = (mode == MODE_MEM2PER) && (c.size != SZ_WORD);
        c.step      = step_of(c.size);
        return c;
    endfunction

endpackage

// File: rtl/dlb_lane_ctrl.sv
module dlb_lane_ctrl
    import dlb_pkg::*;
#(
    parameter int NUM_LANES = LANES,
    parameter int P_W       = PTR_W,
    parameter int S_W       = STEP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           soft_rst,
    input  logic           chan_en,
    input  logic           narrow_rd,
    input  logic           narrow_wr,
    input  logic [S_W-1:0] step,
    input  logic           rd_ack,
    input  logic           wr_ack,
    output logic           rd_req,
    output logic           wr_req,
    output logic           rd_fire,
    output logic           full,
    output logic [P_W-1:0] lane_ptr
);

    localparam int SUM_W = P_W + 1;

    logic             full_q;
    logic [P_W-1:0]   ptr_q;
    logic             narrow_now;
    logic             wr_fire;
    logic [SUM_W-1:0] ptr_sum;
    logic             last_lane;

    assign rd_req     = chan_en & ~full_q;
    assign wr_req     = chan_en & full_q;
    assign rd_fire    = rd_req & rd_ack;
    assign wr_fire    = wr_req & wr_ack;
    assign narrow_now = full_q ? narrow_wr : narrow_rd;
    assign ptr_sum    = {1'b0, ptr_q} + SUM_W'(step);
    assign last_lane  = !narrow_now || (ptr_sum >= SUM_W'(NUM_LANES));

    always_ff @(posedge clk) begin
        if (rst || soft_rst || !chan_en) begin
            full_q <= 1'b0;
            ptr_q  <= '0;
        end else if (rd_fire || wr_fire) begin
            if (last_lane) begin
                full_q <= ~full_q;
                ptr_q  <= '0;
            end else begin
                ptr_q  <= ptr_sum[P_W-1:0];
            end
        end
    end

    assign full     = full_q;
    assign lane_ptr = ptr_q;

endmodule

// File: rtl/dlb_pack.sv
module dlb_pack
    import dlb_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int P_W = PTR_W,
    parameter int S_W = STEP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_fire,
    input  logic           narrow,
    input  logic [P_W-1:0] lane_ptr,
    input  logic [S_W-1:0] step,
    input  logic [W-1:0]   rd_data,
    output logic [W-1:0]   buf_q
);

    localparam int NL    = W / 8;
    localparam int SUM_W = P_W + 1;
    localparam int SH_W  = $clog2(W);

    logic [SH_W-1:0]  shamt;
    logic [W-1:0]     placed;
    logic [SUM_W-1:0] lo_lane;
    logic [SUM_W-1:0] hi_lane;

    assign shamt   = SH_W'({lane_ptr, 3'b000});
    assign placed  = narrow ? (rd_data << shamt) : rd_data;
    assign lo_lane = {1'b0, lane_ptr};
    assign hi_lane = lo_lane + SUM_W'(step);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic take;
        assign take = !narrow || ((SUM_W'(i) >= lo_lane) && (SUM_W'(i) < hi_lane));
        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q[8*i +: 8] <= '0;
            end else if (rd_fire && take) begin
                buf_q[8*i +: 8] <= placed[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/dlb_unpack.sv
module dlb_unpack
    import dlb_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int P_W = PTR_W,
    parameter int S_W = STEP_W
) (
    input  logic [W-1:0]   buf_q,
    input  logic           narrow,
    input  logic [P_W-1:0] lane_ptr,
    input  logic [S_W-1:0] step,
    output logic [W-1:0]   wr_data
);

    localparam int NL   = W / 8;
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] shamt;
    logic [W-1:0]    lowered;

    assign shamt   = SH_W'({lane_ptr, 3'b000});
    assign lowered = narrow ? (buf_q >> shamt) : buf_q;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic keep;
        assign keep = !narrow || (i < int'(step));
        assign wr_data[8*i +: 8] = keep ? lowered[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/dma_lane_buffer.sv
module dma_lane_buffer
    import dlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              chan_en,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        width_sel,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_req,
    input  logic              wr_ack,
    output logic [WORD_W-1:0] wr_data,
    output logic [1:0]        xfer_size,
    output logic [PTR_W-1:0]  lane_ptr
);

    path_cfg_t         cfg;
    logic              full;
    logic              rd_fire;
    logic [WORD_W-1:0] buf_q;

    assign cfg = decode_path(mode_sel, width_sel);

    dlb_lane_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .chan_en   (chan_en),
        .narrow_rd (cfg.narrow_rd),
        .narrow_wr (cfg.narrow_wr),
        .step      (cfg.step),
        .rd_ack    (rd_ack),
        .wr_ack    (wr_ack),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .rd_fire   (rd_fire),
        .full      (full),
        .lane_ptr  (lane_ptr)
    );

    dlb_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .rd_fire  (rd_fire),
        .narrow   (cfg.narrow_rd),
        .lane_ptr (lane_ptr),
        .step     (cfg.step),
        .rd_data  (rd_data),
        .buf_q    (buf_q)
    );

    dlb_unpack u_unpack (
        .buf_q    (buf_q),
        .narrow   (cfg.narrow_wr),
        .lane_ptr (lane_ptr),
        .step     (cfg.step),
        .wr_data  (wr_data)
    );

    assign xfer_size = (full ? cfg.narrow_wr : cfg.narrow_rd) ? cfg.size : SZ_WORD;

endmodule

// File: rtl/dlb_checker.sv
module dlb_checker (
    input logic        clk,
    input logic        rst,
    input logic        soft_rst,
    input logic        chan_en,
    input logic [1:0]  mode_sel,
    input logic        rd_req,
    input logic        wr_req,
    input logic        wr_ack,
    input logic [31:0] wr_data,
    input logic [1:0]  xfer_size,
    input logic [3:0]  lane_ptr
);

    p_req_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    p_mem2mem_word_r2: assert property (@(posedge clk) disable iff (rst)
        ((mode_sel == 2'b00) && (rd_req || wr_req)) |-> (xfer_size == 2'b00));

    p_ptr_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        (lane_ptr < 4'd4) && ((xfer_size == 2'b10) ? !lane_ptr[0] : 1'b1));

    p_softrst_clear_r11: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (lane_ptr == 4'd0) && !wr_req);

    p_reenable_fresh_r10: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !$past(chan_en) && !$past(rst)) |-> (rd_req && !wr_req && lane_ptr == 4'd0));

    p_write_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack && !soft_rst && chan_en) |=>
            (!chan_en || (wr_req && $stable(lane_ptr) && $stable(wr_data))));

endmodule

bind dma_lane_buffer dlb_checker u_dlb_checker (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .chan_en   (chan_en),
    .mode_sel  (mode_sel),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .wr_ack    (wr_ack),
    .wr_data   (wr_data),
    .xfer_size (xfer_size),
    .lane_ptr  (lane_ptr)
);

// File: tb/tb_dma_lane_buffer.sv
module tb_dma_lane_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        chan_en = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  width_sel = 2'b00;
    logic        rd_req;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        wr_req;
    logic        wr_ack = 1'b0;
    logic [31:0] wr_data;
    logic [1:0]  xfer_size;
    logic [3:0]  lane_ptr;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    dma_lane_buffer dut (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .chan_en   (chan_en),
        .mode_sel  (mode_sel),
        .width_sel (width_sel),
        .rd_req    (rd_req),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .wr_req    (wr_req),
        .wr_ack    (wr_ack),
        .wr_data   (wr_data),
        .xfer_size (xfer_size),
        .lane_ptr  (lane_ptr)
    );

    // mode(2) width(2) word(32)
    localparam logic [35:0] VECS [0:7] = '{
        {2'b10, 2'b01, 32'hA1B2C3D4},
        {2'b10, 2'b10, 32'h1234ABCD},
        {2'b10, 2'b00, 32'hDEADBEEF},
        {2'b01, 2'b01, 32'h0F1E2D3C},
        {2'b01, 2'b10, 32'h55AA33CC},
        {2'b01, 2'b00, 32'h89ABCDEF},
        {2'b00, 2'b01, 32'h13579BDF},
        {2'b10, 2'b11, 32'h2468ACE0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m, input logic [1:0] w);
        if (m == 2'b00 || m == 2'b11) return "R2";
        if (w == 2'b11) return "R3";
        if (w == 2'b00) return "R9";
        if (m == 2'b10) return (w == 2'b01) ? "R4" : "R5";
        return (w == 2'b01) ? "R7" : "R8";
    endfunction

    // called at a negedge; returns at the negedge after the transfer edge
    task automatic do_read(input logic [31:0] d, input logic [1:0] esz,
                           input logic [3:0] eptr, input string req);
        chk(rd_req === 1'b1 && wr_req === 1'b0, req, "read requested", {30'b0, rd_req, wr_req}, 32'h2);
        chk(xfer_size === esz, "R3", "read size", {30'b0, xfer_size}, {30'b0, esz});
        chk(lane_ptr === eptr, req, "read lane_ptr", {28'b0, lane_ptr}, {28'b0, eptr});
        rd_data = d;
        rd_ack  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_ack  = 1'b0;
        rd_data = 32'hFFFF_FFFF;
    endtask

    task automatic do_write(input logic [31:0] ed, input logic [1:0] esz,
                            input logic [3:0] eptr, input string req);
        chk(wr_req === 1'b1 && rd_req === 1'b0, "R6", "write only, no read", {30'b0, rd_req, wr_req}, 32'h1);
        chk(wr_data === ed, req, "write data", wr_data, ed);
        chk(xfer_size === esz, "R3", "write size", {30'b0, xfer_size}, {30'b0, esz});
        chk(lane_ptr === eptr, req, "write lane_ptr", {28'b0, lane_ptr}, {28'b0, eptr});
        wr_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_ack = 1'b0;
    endtask

    task automatic run_vec(input logic [1:0] m, input logic [1:0] w, input logic [31:0] word);
        logic [1:0]  esz;
        int          stp;
        logic [31:0] mask;
        string       req;
        req  = tag_of(m, w);
        esz  = (m == 2'b01 || m == 2'b10) ? ((w == 2'b11) ? 2'b00 : w) : 2'b00;
        stp  = (esz == 2'b01) ? 1 : (esz == 2'b10) ? 2 : 4;
        mask = (stp == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * stp)) - 1);
        mode_sel  = m;
        width_sel = w;
        @(negedge clk);
        if (m == 2'b01) begin
            for (int p = 0; p < 4; p += stp)
                do_read(((word >> (8 * p)) & mask) | (~mask & 32'hC0DE_C0DE), esz, 4'(p), req);
            do_write(word, 2'b00, 4'd0, req);
        end else if (m == 2'b10) begin
            do_read(word, 2'b00, 4'd0, req);
            for (int p = 0; p < 4; p += stp)
                do_write((word >> (8 * p)) & mask, esz, 4'(p), req);
        end else begin
            do_read(word, 2'b00, 4'd0, req);
            do_write(word, 2'b00, 4'd0, req);
        end
        chk(rd_req === 1'b1 && lane_ptr === 4'd0, req, "ready for next word", {27'b0, rd_req, lane_ptr}, 32'h10);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R12 watchdog expired: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst     = 1'b0;
        chan_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_req === 1'b1 && wr_req === 1'b0, "R1", "requests after reset", {30'b0, rd_req, wr_req}, 32'h2);
        chk(lane_ptr === 4'd0, "R1", "lane_ptr after reset", {28'b0, lane_ptr}, 32'h0);

        for (int i = 0; i < 8; i++)
            run_vec(VECS[i][35:34], VECS[i][33:32], VECS[i][31:0]);

        // R12: write held while ack low
        mode_sel  = 2'b10;
        width_sel = 2'b01;
        @(negedge clk);
        do_read(32'h7788_99AA, 2'b00, 4'd0, "R4");
        repeat (3) begin
            @(negedge clk);
            chk(wr_req === 1'b1 && wr_data === 32'h0000_00AA && lane_ptr === 4'd0,
                "R12", "held write", wr_data, 32'h0000_00AA);
        end
        do_write(32'h0000_00AA, 2'b01, 4'd0, "R12");
        do_write(32'h0000_0099, 2'b01, 4'd1, "R12");
        do_write(32'h0000_0088, 2'b01, 4'd2, "R12");
        do_write(32'h0000_0077, 2'b01, 4'd3, "R12");

        // R10: disable in the middle of a half-word drain
        width_sel = 2'b10;
        @(negedge clk);
        do_read(32'hCAFE_F00D, 2'b00, 4'd0, "R10");
        do_write(32'h0000_F00D, 2'b10, 4'd0, "R10");
        chan_en = 1'b0;
        @(negedge clk);
        chk(rd_req === 1'b0 && wr_req === 1'b0, "R10", "requests while disabled", {30'b0, rd_req, wr_req}, 32'h0);
        chan_en = 1'b1;
        @(negedge clk);
        chk(rd_req === 1'b1 && wr_req === 1'b0 && lane_ptr === 4'd0, "R10", "fresh start after re-enable",
            {27'b0, rd_req, lane_ptr}, 32'h10);
        do_read(32'h0BAD_BEEF, 2'b00, 4'd0, "R10");
        do_write(32'h0000_BEEF, 2'b10, 4'd0, "R10");
        do_write(32'h0000_0BAD, 2'b10, 4'd2, "R10");

        // R11: soft reset in the middle of a byte fill
        mode_sel  = 2'b01;
        width_sel = 2'b01;
        @(negedge clk);
        do_read(32'h0000_0011, 2'b01, 4'd0, "R11");
        do_read(32'h0000_0022, 2'b01, 4'd1, "R11");
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(lane_ptr === 4'd0 && rd_req === 1'b1, "R11", "pointer cleared by soft reset",
            {27'b0, rd_req, lane_ptr}, 32'h10);
        do_read(32'hFFFF_FF44, 2'b01, 4'd0, "R11");
        do_read(32'hFFFF_FF55, 2'b01, 4'd1, "R11");
        do_read(32'hFFFF_FF66, 2'b01, 4'd2, "R11");
        do_read(32'hFFFF_FF77, 2'b01, 4'd3, "R11");
        do_write(32'h7766_5544, 2'b00, 4'd0, "R11");

        finish_run();
    end

endmodule